// File: doc/BRIEF.md
# Double-Precision Reciprocal Estimate Unit

This unit takes one IEEE-754 double-precision operand and produces a bit-exact estimate of its reciprocal, also as a double. The estimate is not a true quotient. It comes from a piecewise-linear approximation with 32 segments. Each segment holds a starting value and a slope, and the slope is scaled by ten bits of the mantissa below the segment selector. The result carries a 23-bit mantissa field, and its low 29 bits are always zero.

Special operands get fixed results. These are signed zeros, infinities, NaNs, tiny magnitudes (including subnormals) and very large magnitudes. A zero operand also raises a divide-by-zero flag. The unit has no handshake. An operand presented with `in_valid` produces its result and flag, with `out_valid`, on the next clock edge. One operand can be accepted every cycle.

Top module: `rcp_est_top`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low in the cycle after each cycle in which `in_valid` is low.
- R2: For a normal operand with biased exponent e, where 895 <= e <= 1148, the result sign (bit 63) equals the operand sign. The result exponent field (bits 62:52) equals 2045 - e.
- R3: For such an operand, let s be operand bits 51:47 and f be bits 46:37. Result bits 51:29 equal B[s] - ((D[s]*f + 1) >> 1), and result bits 28:0 are zero. B is the 32-entry start table, running from 0x7FF800 down to 0x020C00. D is the 32-entry slope table, running from 0x3E1 down to 0x106.
- R4: An operand of +0 or -0 returns an infinity of the same sign (exponent 0x7FF, mantissa 0) with `out_dz` high. For every other operand, `out_dz` is low.
- R5: An operand of +infinity or -infinity returns a zero of the same sign.
- R6: A NaN operand is returned with bit 51 forced to 1. All other bits keep their input values.
- R7: A nonzero operand with biased exponent below 895, subnormals included, returns the largest finite single-precision magnitude as a double (0x47EFFFFFE0000000) with the operand sign.
- R8: A finite operand with biased exponent 1149 or more returns a zero of the same sign.
- R9: After synchronous reset, `out_valid`, `out_dz` and `out_result` are all zero.
- R10: In a cycle with `in_valid` low, the operand is ignored. `out_result` and `out_dz` keep the values of the last accepted operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand valid this cycle |
| in_op | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result valid this cycle |
| out_result | output | 64 | Double-precision reciprocal estimate |
| out_dz | output | 1 | Divide-by-zero flag for the result |

## Verification
There is only one register stage, so any internal fault shows on the outputs in the cycle right after the operand that triggers it. A wrong table entry affects only operands whose segment selector picks that entry. For that reason the sweep covers every segment at both ends of the fraction range and at interior points. A wrong classification boundary appears only at the exponents on either side of 895 and 1149, or on zero, infinity and NaN encodings, and each of these is applied directly. A corrupted output register appears at the next idle cycle, as a result or flag that changes when it should hold.

// File: rtl/rcp_est_pkg.sv
package rcp_est_pkg;
  localparam int DW      = 64;
  localparam int EW      = 11;
  localparam int MW      = 52;
  localparam int SEG_W   = 5;
  localparam int FRAC_W  = 10;
  localparam int START_W = 23;
  localparam int SLOPE_W = 10;
  localparam int OUT_LSB = MW - START_W;
  localparam int NSEG    = 1 << SEG_W;

  typedef enum logic [2:0] {
    K_NORM, K_ZERO, K_INF, K_NAN, K_TINY, K_HUGE
  } kind_e;

  function automatic logic [START_W-1:0] start_of(input logic [SEG_W-1:0] s);
    case (s)
      5'd0:  start_of = 23'h7FF800;  5'd1:  start_of = 23'h783800;
      5'd2:  start_of = 23'h70EA00;  5'd3:  start_of = 23'h6A0800;
      5'd4:  start_of = 23'h638800;  5'd5:  start_of = 23'h5D6200;
      5'd6:  start_of = 23'h579000;  5'd7:  start_of = 23'h520800;
      5'd8:  start_of = 23'h4CC800;  5'd9:  start_of = 23'h47CA00;
      5'd10: start_of = 23'h430800;  5'd11: start_of = 23'h3E8000;
      5'd12: start_of = 23'h3A2C00;  5'd13: start_of = 23'h360800;
      5'd14: start_of = 23'h321400;  5'd15: start_of = 23'h2E4A00;
      5'd16: start_of = 23'h2AA800;  5'd17: start_of = 23'h272C00;
      5'd18: start_of = 23'h23D600;  5'd19: start_of = 23'h209E00;
      5'd20: start_of = 23'h1D8800;  5'd21: start_of = 23'h1A9000;
      5'd22: start_of = 23'h17AE00;  5'd23: start_of = 23'h14F800;
      5'd24: start_of = 23'h124400;  5'd25: start_of = 23'h0FBE00;
      5'd26: start_of = 23'h0D3800;  5'd27: start_of = 23'h0ADE00;
      5'd28: start_of = 23'h088400;  5'd29: start_of = 23'h065000;
      5'd30: start_of = 23'h041C00;  default: start_of = 23'h020C00;
    endcase
  endfunction

  function automatic logic [SLOPE_W-1:0] slope_of(input logic [SEG_W-1:0] s);
    case (s)
      5'd0:  slope_of = 10'h3E1;  5'd1:  slope_of = 10'h3A7;
      5'd2:  slope_of = 10'h371;  5'd3:  slope_of = 10'h340;
      5'd4:  slope_of = 10'h313;  5'd5:  slope_of = 10'h2EA;
      5'd6:  slope_of = 10'h2C4;  5'd7:  slope_of = 10'h2A0;
      5'd8:  slope_of = 10'h27F;  5'd9:  slope_of = 10'h261;
      5'd10: slope_of = 10'h245;  5'd11: slope_of = 10'h22A;
      5'd12: slope_of = 10'h212;  5'd13: slope_of = 10'h1FB;
      5'd14: slope_of = 10'h1E5;  5'd15: slope_of = 10'h1D1;
      5'd16: slope_of = 10'h1BE;  5'd17: slope_of = 10'h1AC;
      5'd18: slope_of = 10'h19B;  5'd19: slope_of = 10'h18B;
      5'd20: slope_of = 10'h17C;  5'd21: slope_of = 10'h16E;
      5'd22: slope_of = 10'h15B;  5'd23: slope_of = 10'h15B;
      5'd24: slope_of = 10'h143;  5'd25: slope_of = 10'h143;
      5'd26: slope_of = 10'h12D;  5'd27: slope_of = 10'h12D;
      5'd28: slope_of = 10'h11A;  5'd29: slope_of = 10'h11A;
      5'd30: slope_of = 10'h108;  default: slope_of = 10'h106;
    endcase
  endfunction
endpackage

// File: rtl/rcp_classify.sv
module rcp_classify
  import rcp_est_pkg::*;
#(
  parameter int LO_EXP = 895,
  parameter int HI_EXP = 1149
) (
  input  logic [DW-1:0] op,
  output kind_e         kind
);
  localparam logic [EW-1:0] EXP_ALL1 = {EW{1'b1}};
  localparam logic [EW-1:0] LO_E     = EW'(LO_EXP);
  localparam logic [EW-1:0] HI_E     = EW'(HI_EXP);

  logic [EW-1:0] ex;
  logic          mant_nz;

  assign ex      = op[DW-2 -: EW];
  assign mant_nz = |op[MW-1:0];

  always_comb begin
    if (ex == '0 && !mant_nz)  kind = K_ZERO;
    else if (ex == EXP_ALL1)   kind = mant_nz ? K_NAN : K_INF;
    else if (ex < LO_E)        kind = K_TINY;
    else if (ex >= HI_E)       kind = K_HUGE;
    else                       kind = K_NORM;
  end
endmodule

// File: rtl/rcp_seg_rom.sv
module rcp_seg_rom
  import rcp_est_pkg::*;
(
  input  logic [SEG_W-1:0]   seg,
  output logic [START_W-1:0] start_val,
  output logic [SLOPE_W-1:0] slope_val
);
  always_comb begin
    start_val = start_of(seg);
    slope_val = slope_of(seg);
  end
endmodule

// File: rtl/rcp_interp.sv
module rcp_interp
  import rcp_est_pkg::*;
(
  input  logic [START_W-1:0] start_val,
  input  logic [SLOPE_W-1:0] slope_val,
  input  logic [FRAC_W-1:0]  frac,
  output logic [START_W-1:0] mant
);
  localparam int PROD_W = SLOPE_W + FRAC_W + 1;

  logic [PROD_W-1:0]  prod;
  logic [PROD_W-2:0]  half;
  logic [START_W:0]   diff;

  assign prod = PROD_W'(slope_val) * PROD_W'(frac) + PROD_W'(1);
  assign half = prod[PROD_W-1:1];
  assign diff = {1'b0, start_val} - (START_W+1)'(half);
  assign mant = diff[START_W-1:0];
endmodule

// File: rtl/rcp_est_top.sv
module rcp_est_top
  import rcp_est_pkg::*;
#(
  parameter int LO_EXP = 895,
  parameter int HI_EXP = 1149
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [63:0]   in_op,
  output logic          out_valid,
  output logic [63:0]   out_result,
  output logic          out_dz
);
  localparam logic [EW:0]   EXP_MIRROR = (EW+1)'((1 << EW) - 3);
  localparam logic [DW-2:0] SGL_MAX    = 63'h47EFFFFFE0000000;

  kind_e               kind;
  logic [START_W-1:0]  start_val;
  logic [SLOPE_W-1:0]  slope_val;
  logic [START_W-1:0]  mant;
  logic [EW:0]         exp_diff;
  logic [DW-1:0]       nxt_result;
  logic                nxt_dz;
  logic                sgn;

  rcp_classify #(.LO_EXP(LO_EXP), .HI_EXP(HI_EXP)) u_cls (
    .op(in_op), .kind(kind)
  );

  rcp_seg_rom u_rom (
    .seg(in_op[MW-1 -: SEG_W]), .start_val(start_val), .slope_val(slope_val)
  );

  rcp_interp u_interp (
    .start_val(start_val), .slope_val(slope_val),
    .frac(in_op[MW-1-SEG_W -: FRAC_W]), .mant(mant)
  );

  assign sgn      = in_op[DW-1];
  assign exp_diff = EXP_MIRROR - {1'b0, in_op[DW-2 -: EW]};

  always_comb begin
    nxt_dz = 1'b0;
    case (kind)
      K_NORM:  nxt_result = {sgn, exp_diff[EW-1:0], mant, {OUT_LSB{1'b0}}};
      K_ZERO:  begin
        nxt_result = {sgn, {EW{1'b1}}, {MW{1'b0}}};
        nxt_dz     = 1'b1;
      end
      K_NAN:   nxt_result = in_op | (64'd1 << (MW-1));
      K_TINY:  nxt_result = {sgn, SGL_MAX};
      default: nxt_result = {sgn, {(DW-1){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_dz     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_result;
        out_dz     <= nxt_dz;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r4_zero_gives_inf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[62:0] == '0) |=> (out_dz && out_result[62:0] == 63'h7FF0000000000000));
  a_r5_inf_gives_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[62:0] == 63'h7FF0000000000000) |=> (out_result[62:0] == '0 && !out_dz));
  a_r3_low_bits_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[62:52] >= 11'(LO_EXP) && in_op[62:52] < 11'(HI_EXP))
      |=> (out_result[OUT_LSB-1:0] == '0 && out_result[63] == $past(in_op[63])));
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_dz)));
endmodule

// File: tb/tb_rcp_est_top.sv
module tb_rcp_est_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_op;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_dz;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rcp_est_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_result(out_result), .out_dz(out_dz)
  );

  function automatic int ref_start(input int s);
    int t[32] = '{'h7FF800,'h783800,'h70EA00,'h6A0800,'h638800,'h5D6200,'h579000,'h520800,
                  'h4CC800,'h47CA00,'h430800,'h3E8000,'h3A2C00,'h360800,'h321400,'h2E4A00,
                  'h2AA800,'h272C00,'h23D600,'h209E00,'h1D8800,'h1A9000,'h17AE00,'h14F800,
                  'h124400,'h0FBE00,'h0D3800,'h0ADE00,'h088400,'h065000,'h041C00,'h020C00};
    return t[s];
  endfunction

  function automatic int ref_slope(input int s);
    int t[32] = '{'h3E1,'h3A7,'h371,'h340,'h313,'h2EA,'h2C4,'h2A0,
                  'h27F,'h261,'h245,'h22A,'h212,'h1FB,'h1E5,'h1D1,
                  'h1BE,'h1AC,'h19B,'h18B,'h17C,'h16E,'h15B,'h15B,
                  'h143,'h143,'h12D,'h12D,'h11A,'h11A,'h108,'h106};
    return t[s];
  endfunction

  // reference model built from the requirements; returns requirement tag in tag
  task automatic model(input logic [63:0] op, output logic [63:0] r, output logic dz,
                       output string tag);
    int e;
    longint m;
    int s, f, v;
    e  = int'(op[62:52]);
    m  = longint'(op[51:0]);
    dz = 1'b0;
    if (e == 0 && m == 0) begin
      r = {op[63], 11'h7FF, 52'd0}; dz = 1'b1; tag = "R4";
    end else if (e == 2047 && m == 0) begin
      r = {op[63], 63'd0}; tag = "R5";
    end else if (e == 2047) begin
      r = op; r[51] = 1'b1; tag = "R6";
    end else if (e < 895) begin
      r = {op[63], 63'h47EFFFFFE0000000}; tag = "R7";
    end else if (e >= 1149) begin
      r = {op[63], 63'd0}; tag = "R8";
    end else begin
      s = int'(op[51:47]);
      f = int'(op[46:37]);
      v = ref_start(s) - (ref_slope(s) * f + 1) / 2;
      r = {op[63], 11'(2045 - e), 23'(v), 29'd0}; tag = "R2/R3";
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic apply(input logic [63:0] op);
    logic [63:0] r;
    logic dz;
    string tag;
    model(op, r, dz, tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 valid", {63'd0, out_valid}, 64'd1);
    check(tag, out_result, r);
    check({tag, " R4 flag"}, {63'd0, out_dz}, {63'd0, dz});
  endtask

  initial begin
    #(5.0 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; in_valid = 1'b0; in_op = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", {63'd0, out_valid}, 64'd0);
    check("R9 result", out_result, 64'd0);
    check("R9 dz", {63'd0, out_dz}, 64'd0);
    rst = 1'b0;

    // R2 R3 sweep: every segment, edge and interior fractions, several exponents
    for (int s = 0; s < 32; s++)
      for (int fi = 0; fi < 4; fi++)
        for (int ei = 0; ei < 3; ei++) begin
          logic [9:0] f;
          logic [10:0] e;
          f = (fi == 0) ? 10'd0 : (fi == 1) ? 10'd1 : (fi == 2) ? 10'd511 : 10'd1023;
          e = (ei == 0) ? 11'd895 : (ei == 1) ? 11'd1023 : 11'd1148;
          apply({1'(s + fi), e, 5'(s), f, 37'(64'h15_5555_5555 + s)});
        end

    // random normal and any operands
    for (int k = 0; k < 400; k++)
      apply({$urandom(), $urandom()});

    // R4 zeros, R5 infinities
    apply(64'h0000000000000000);
    apply(64'h8000000000000000);
    apply(64'h7FF0000000000000);
    apply(64'hFFF0000000000000);
    // R6 NaNs, signalling and quiet
    apply(64'h7FF0000000000001);
    apply(64'hFFF4000000ABCDEF);
    apply(64'h7FF8000000000000);
    // R7 tiny and subnormal, boundary 894 / 895
    apply(64'h0000000000000001);
    apply(64'h800FFFFFFFFFFFFF);
    apply({1'b1, 11'd894, 52'hFFFFFFFFFFFFF});
    apply({1'b0, 11'd895, 52'd0});
    // R8 huge, boundary 1148 / 1149
    apply({1'b0, 11'd1148, 52'hFFFFFFFFFFFFF});
    apply({1'b1, 11'd1149, 52'd0});
    apply({1'b0, 11'd2046, 52'hFFFFFFFFFFFFF});

    // R10 idle operand ignored, R1 valid drops
    apply(64'h0000000000000000);
    held = out_result;
    in_op = 64'h3FF0000000000000;
    @(negedge clk);
    check("R1 idle valid", {63'd0, out_valid}, 64'd0);
    check("R10 result hold", out_result, held);
    check("R10 dz hold", {63'd0, out_dz}, 64'd1);

    // R9 reset again clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 result after reset", out_result, 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule